// File: doc/BRIEF.md
# Digital PLL Loop Sequencer

This block decides what a digital PLL is doing at any moment: running open on a programmed frequency, tracking an input reference, coasting in holdover, or moving from one reference to another. It also picks the 48-bit frequency tuning word that feeds the synthesizer. A reference change always goes through two short steps, each one cycle long. In the first step the loop is opened and a held word is used. In the second step a profile-load strobe is raised so that the new reference's loop settings can be applied. The loop is closed only after that. The lock-detector status is frozen during these two steps, so a reference change never shows up as a false loss of lock.

When the loop is open for holdover, the held tuning word is picked in priority order. A valid history average comes first. If there is no history, a fallback bit picks either the last live loop word or the programmed free-run word. The held word is captured once, on entry, and does not change after that. Software control bits can force free-run or holdover, and can pin the loop to one chosen reference.

All pins are plain levels sampled on the clock. None carries a data stream, so the block has no valid/ready handshake and no back-pressure. The live loop word and the free-run word are treated as always valid.

Top module: `dpll_loop_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is in free-run: `loop_closed`=0, `profile_load`=0, `active_ref`=0 and `ftw_out` equals `freerun_ftw`.
- R2: When `force_freerun` is 1 at a clock edge, the block is in free-run from the next cycle on, with `loop_closed`=0 and `ftw_out`=`freerun_ftw`. This takes priority over `force_hold` and over every automatic transition.
- R3: When `force_hold` is 1 and `force_freerun` is 0 at a clock edge, the block is in holdover from the next cycle on, with `loop_closed`=0 and `ftw_out` equal to the held word.
- R4: Acquisition takes exactly one switch cycle (loop open, held word, `active_ref` already set to the new reference), then one load cycle (loop open, `profile_load`=1), then tracking (`loop_closed`=1, `ftw_out` follows `loop_ftw` in the same cycle). `profile_load` is never high for two cycles in a row.
- R5: The target reference is chosen as follows. With `force_ref_en`=1 the target is `force_ref_idx`, and it counts as available only if its valid bit is set. Otherwise the target is the current `active_ref` while its valid bit is set, and the lowest-index valid reference when it is not. A newly valid reference never pulls the loop away from a valid active one.
- R6: While tracking, if the active reference is no longer the available target, the block starts a switchover to the target when one is available. If no target is available, it enters holdover.
- R7: On entry to holdover (or to the switch step) from tracking or free-run, a set `hist_valid` makes the held word equal to `hist_ftw`.
- R8: On that entry, with `hist_valid`=0 and `fallback_single`=1, the held word is the `loop_ftw` value present in the last cycle before entry.
- R9: On that entry, with `hist_valid`=0 and `fallback_single`=0, the held word is the `freerun_ftw` value present at entry. Later changes to `freerun_ftw` do not move it.
- R10: `ftw_out` stays constant for as long as the block remains in holdover, switch or load, whatever the word inputs do.
- R11: In the switch and load cycles, `lock_out` keeps the `lock_in` value of the last cycle before the switch. Otherwise `lock_out` equals `lock_in`.
- R12: From holdover or free-run, when no force is applied and a target is available, the block leaves through the switch and load sequence of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | NREF | Qualified-reference flags, bit i for reference i |
| force_freerun | input | 1 | Software force into free-run |
| force_hold | input | 1 | Software force into holdover |
| force_ref_en | input | 1 | Pin the loop to `force_ref_idx` |
| force_ref_idx | input | REF_W | Reference chosen by software |
| fallback_single | input | 1 | Without history: 1 = hold last loop word, 0 = hold free-run word |
| hist_valid | input | 1 | A history average exists |
| hist_ftw | input | FTW_W | History average tuning word |
| loop_ftw | input | FTW_W | Live closed-loop tuning word |
| freerun_ftw | input | FTW_W | Programmed free-run tuning word |
| lock_in | input | NLOCK | Raw lock-detector flags |
| active_ref | output | REF_W | Reference currently selected |
| loop_closed | output | 1 | 1 while tracking (closed loop) |
| ftw_out | output | FTW_W | Tuning word sent to the synthesizer |
| profile_load | output | 1 | One-cycle strobe to apply the profile of `active_ref` |
| lock_out | output | NLOCK | Lock flags, frozen during switchover |

## Verification
The bench targets the ordering in holdover-word selection. A design that inverts the fallback bit, or lets history lose priority, holds the wrong one of three distinguishable words. A design that captures the word every cycle instead of only on entry lets the output drift with `loop_ftw` or `freerun_ftw` during holdover. The bench also drives a lock drop in the middle of a switchover: a design without the freeze reports the drop at once. It also makes a lower-index reference valid while tracking, which a revertive or mis-prioritized selector would answer with a needless switchover. Random force pulses arriving while a switchover is in progress check that free-run beats holdover and that the switch, load and track order is never shortened or skipped.

// File: rtl/dpll_lc_pkg.sv
package dpll_lc_pkg;
  typedef enum logic [2:0] {
    LC_FREE  = 3'd0,
    LC_HOLD  = 3'd1,
    LC_SWAP  = 3'd2,
    LC_LOAD  = 3'd3,
    LC_TRACK = 3'd4
  } lc_state_e;

  // open loop driven by the held word
  function automatic logic lc_is_held(lc_state_e s);
    return (s == LC_HOLD) || (s == LC_SWAP) || (s == LC_LOAD);
  endfunction

  // switchover steps with lock status frozen
  function automatic logic lc_is_frozen(lc_state_e s);
    return (s == LC_SWAP) || (s == LC_LOAD);
  endfunction
endpackage

// File: rtl/dpll_lc_refsel.sv
module dpll_lc_refsel #(
  parameter int NREF  = 4,
  parameter int REF_W = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic [NREF-1:0]  ref_valid,
  input  logic [REF_W-1:0] active_ref,
  input  logic             force_ref_en,
  input  logic [REF_W-1:0] force_ref_idx,
  output logic [REF_W-1:0] tgt_idx,
  output logic             tgt_ok
);
  logic [REF_W-1:0] lowest_idx;
  logic             any_valid;

  always_comb begin
    lowest_idx = '0;
    any_valid  = 1'b0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (ref_valid[i]) begin
        lowest_idx = REF_W'(i);
        any_valid  = 1'b1;
      end
    end
  end

  always_comb begin
    if (force_ref_en) begin
      tgt_idx = force_ref_idx;
      tgt_ok  = ref_valid[force_ref_idx];
    end else if (ref_valid[active_ref]) begin
      tgt_idx = active_ref;
      tgt_ok  = 1'b1;
    end else begin
      tgt_idx = lowest_idx;
      tgt_ok  = any_valid;
    end
  end
endmodule

// File: rtl/dpll_lc_fsm.sv
module dpll_lc_fsm
  import dpll_lc_pkg::*;
#(
  parameter int REF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_freerun,
  input  logic             force_hold,
  input  logic [REF_W-1:0] tgt_idx,
  input  logic             tgt_ok,
  output lc_state_e        state_q,
  output lc_state_e        state_d,
  output logic [REF_W-1:0] active_ref
);
  always_comb begin
    state_d = state_q;
    if (force_freerun) begin
      state_d = LC_FREE;
    end else if (force_hold) begin
      state_d = LC_HOLD;
    end else begin
      unique case (state_q)
        LC_FREE, LC_HOLD: if (tgt_ok) state_d = LC_SWAP;
        LC_SWAP:          state_d = LC_LOAD;
        LC_LOAD:          state_d = LC_TRACK;
        LC_TRACK: begin
          if (!tgt_ok)                    state_d = LC_HOLD;
          else if (tgt_idx != active_ref) state_d = LC_SWAP;
        end
        default:          state_d = LC_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= LC_FREE;
      active_ref <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == LC_SWAP && state_q != LC_SWAP) active_ref <= tgt_idx;
    end
  end

  // R4: the loop closes only right after the load step
  a_r4_close_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_TRACK && $past(state_q) != LC_TRACK) |-> $past(state_q) == LC_LOAD);
  // R4: load strobe state lasts one cycle
  a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_LOAD) |=> (state_q != LC_LOAD));
  // R2: a forced free-run always wins
  a_r2_freerun_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_freerun |=> (state_q == LC_FREE));
  // R5: the reference never changes while tracking
  a_r5_ref_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_TRACK && $past(state_q) == LC_TRACK) |-> $stable(active_ref));
endmodule

// File: rtl/dpll_lc_ftw_sel.sv
module dpll_lc_ftw_sel
  import dpll_lc_pkg::*;
#(
  parameter int FTW_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lc_state_e        state_q,
  input  lc_state_e        state_d,
  input  logic             hist_valid,
  input  logic [FTW_W-1:0] hist_ftw,
  input  logic             fallback_single,
  input  logic [FTW_W-1:0] loop_ftw,
  input  logic [FTW_W-1:0] freerun_ftw,
  output logic [FTW_W-1:0] ftw_out
);
  logic [FTW_W-1:0] held_q;
  logic [FTW_W-1:0] held_pick;

  always_comb begin
    if (hist_valid)           held_pick = hist_ftw;
    else if (fallback_single) held_pick = loop_ftw;
    else                      held_pick = freerun_ftw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else if (lc_is_held(state_d) && !lc_is_held(state_q)) held_q <= held_pick;
  end

  always_comb begin
    unique case (state_q)
      LC_TRACK: ftw_out = loop_ftw;
      LC_FREE:  ftw_out = freerun_ftw;
      default:  ftw_out = held_q;
    endcase
  end

  // R10: the held word does not move during an open-loop stretch
  a_r10_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_is_held(state_q) && lc_is_held($past(state_q))) |-> $stable(ftw_out));
endmodule

// File: rtl/dpll_lc_lock_freeze.sv
module dpll_lc_lock_freeze
  import dpll_lc_pkg::*;
#(
  parameter int NLOCK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lc_state_e        state_q,
  input  logic [NLOCK-1:0] lock_in,
  output logic [NLOCK-1:0] lock_out
);
  logic frozen;
  assign frozen = lc_is_frozen(state_q);

  for (genvar g = 0; g < NLOCK; g++) begin : g_bit
    logic kept_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      kept_q <= 1'b0;
      else if (!frozen) kept_q <= lock_in[g];
    end
    assign lock_out[g] = frozen ? kept_q : lock_in[g];
  end

  // R11: lock status holds still across the switch steps
  a_r11_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && lc_is_frozen($past(state_q))) |-> $stable(lock_out));
endmodule

// File: rtl/dpll_loop_ctrl.sv
module dpll_loop_ctrl
  import dpll_lc_pkg::*;
#(
  parameter int NREF  = 4,
  parameter int FTW_W = 48,
  parameter int NLOCK = 2,
  parameter int REF_W = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  ref_valid,
  input  logic             force_freerun,
  input  logic             force_hold,
  input  logic             force_ref_en,
  input  logic [REF_W-1:0] force_ref_idx,
  input  logic             fallback_single,
  input  logic             hist_valid,
  input  logic [FTW_W-1:0] hist_ftw,
  input  logic [FTW_W-1:0] loop_ftw,
  input  logic [FTW_W-1:0] freerun_ftw,
  input  logic [NLOCK-1:0] lock_in,
  output logic [REF_W-1:0] active_ref,
  output logic             loop_closed,
  output logic [FTW_W-1:0] ftw_out,
  output logic             profile_load,
  output logic [NLOCK-1:0] lock_out
);
  lc_state_e        state_q, state_d;
  logic [REF_W-1:0] tgt_idx;
  logic             tgt_ok;

  dpll_lc_refsel #(.NREF(NREF), .REF_W(REF_W)) u_refsel (
    .ref_valid(ref_valid), .active_ref(active_ref),
    .force_ref_en(force_ref_en), .force_ref_idx(force_ref_idx),
    .tgt_idx(tgt_idx), .tgt_ok(tgt_ok)
  );

  dpll_lc_fsm #(.REF_W(REF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .force_freerun(force_freerun), .force_hold(force_hold),
    .tgt_idx(tgt_idx), .tgt_ok(tgt_ok),
    .state_q(state_q), .state_d(state_d), .active_ref(active_ref)
  );

  dpll_lc_ftw_sel #(.FTW_W(FTW_W)) u_ftw (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_d(state_d),
    .hist_valid(hist_valid), .hist_ftw(hist_ftw), .fallback_single(fallback_single),
    .loop_ftw(loop_ftw), .freerun_ftw(freerun_ftw), .ftw_out(ftw_out)
  );

  dpll_lc_lock_freeze #(.NLOCK(NLOCK)) u_lock (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .lock_in(lock_in), .lock_out(lock_out)
  );

  assign loop_closed  = (state_q == LC_TRACK);
  assign profile_load = (state_q == LC_LOAD);

  // R4: strobe is a single-cycle pulse and never coincides with a closed loop
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    profile_load |=> !profile_load);
  a_r4_strobe_open: assert property (@(posedge clk) disable iff (!rst_n)
    profile_load |-> !loop_closed);
  // R3: a forced holdover opens the loop one cycle later
  a_r3_force_open: assert property (@(posedge clk) disable iff (!rst_n)
    force_hold |=> !loop_closed);
endmodule

// File: tb/dpll_loop_ctrl_bench.sv
module dpll_loop_ctrl_bench;
  localparam int NREF = 4, FTW_W = 48, NLOCK = 2, REF_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREF-1:0]  ref_valid = '0;
  logic force_freerun = 0, force_hold = 0, force_ref_en = 0;
  logic [REF_W-1:0] force_ref_idx = '0;
  logic fallback_single = 0, hist_valid = 0;
  logic [FTW_W-1:0] hist_ftw = 48'h5555_6666_7777;
  logic [FTW_W-1:0] loop_ftw = 48'hAAAA_BBBB_CCCC;
  logic [FTW_W-1:0] freerun_ftw = 48'h1111_2222_3333;
  logic [NLOCK-1:0] lock_in = 2'b11;
  logic [REF_W-1:0] active_ref;
  logic loop_closed, profile_load;
  logic [FTW_W-1:0] ftw_out;
  logic [NLOCK-1:0] lock_out;

  always #4 clk = ~clk;

  dpll_loop_ctrl u_dpll_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .force_freerun(force_freerun),
    .force_hold(force_hold), .force_ref_en(force_ref_en), .force_ref_idx(force_ref_idx),
    .fallback_single(fallback_single), .hist_valid(hist_valid), .hist_ftw(hist_ftw),
    .loop_ftw(loop_ftw), .freerun_ftw(freerun_ftw), .lock_in(lock_in),
    .active_ref(active_ref), .loop_closed(loop_closed), .ftw_out(ftw_out),
    .profile_load(profile_load), .lock_out(lock_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 free, 1 hold, 2 switch, 3 load, 4 track
  int               m_st = 0;
  logic [REF_W-1:0] m_ref = '0;
  logic [FTW_W-1:0] m_held = '0;
  logic [NLOCK-1:0] m_lock = '0;

  function automatic bit held(int s); return s == 1 || s == 2 || s == 3; endfunction
  function automatic bit frz(int s);  return s == 2 || s == 3; endfunction

  function automatic logic [FTW_W-1:0] exp_ftw();
    if (m_st == 0) return freerun_ftw;
    if (m_st == 4) return loop_ftw;
    return m_held;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_ref = '0; m_held = '0; m_lock = '0;
  endtask

  task automatic model_next();
    logic [REF_W-1:0] t; bit ok; int nx;
    if (force_ref_en) begin t = force_ref_idx; ok = ref_valid[force_ref_idx]; end
    else if (ref_valid[m_ref]) begin t = m_ref; ok = 1; end
    else begin
      ok = 0; t = '0;
      for (int i = NREF - 1; i >= 0; i--) if (ref_valid[i]) begin t = REF_W'(i); ok = 1; end
    end
    if (force_freerun) nx = 0;
    else if (force_hold) nx = 1;
    else case (m_st)
      0, 1: nx = ok ? 2 : m_st;
      2: nx = 3;
      3: nx = 4;
      default: nx = !ok ? 1 : (t != m_ref ? 2 : 4);
    endcase
    if (!frz(m_st)) m_lock = lock_in;
    if (held(nx) && !held(m_st))
      m_held = hist_valid ? hist_ftw : (fallback_single ? loop_ftw : freerun_ftw);
    if (nx == 2 && m_st != 2) m_ref = t;
    m_st = nx;
  endtask

  // compare all outputs against the model, advance it, move to next negedge
  task automatic step(string tag);
    #1;
    chk({tag, " R4 loop_closed"}, 64'(loop_closed), 64'(m_st == 4));
    chk({tag, " R4 profile_load"}, 64'(profile_load), 64'(m_st == 3));
    chk({tag, " R5 active_ref"}, 64'(active_ref), 64'(m_ref));
    chk({tag, " R10 ftw_out"}, 64'(ftw_out), 64'(exp_ftw()));
    chk({tag, " R11 lock_out"}, 64'(lock_out), 64'(frz(m_st) ? m_lock : lock_in));
    model_next();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset closed", 64'(loop_closed), 64'd0);
    chk("R1 reset ftw", 64'(ftw_out), 64'(freerun_ftw));
    chk("R1 reset ref", 64'(active_ref), 64'd0);
    chk("R1 reset load", 64'(profile_load), 64'd0);
    @(negedge clk);
    rst_n = 1;
    step("R1");
    step("R1");
    // R12 and R4: acquire reference 2 from free-run
    ref_valid = 4'b0100;
    step("R12");
    lock_in = 2'b00;                               // drop lock during switch
    #1; chk("R11 frozen lock", 64'(lock_out), 64'b11);
    chk("R4 switch ref", 64'(active_ref), 64'd2);
    step("R4");
    #1; chk("R4 load strobe", 64'(profile_load), 64'd1);
    chk("R11 frozen lock load", 64'(lock_out), 64'b11);
    step("R4");
    #1; chk("R4 tracking", 64'(loop_closed), 64'd1);
    chk("R4 live word", 64'(ftw_out), 64'(loop_ftw));
    chk("R11 lock passes", 64'(lock_out), 64'b00);
    lock_in = 2'b11;
    // R5 non-revertive
    ref_valid = 4'b0101;
    step("R5"); step("R5");
    #1; chk("R5 stays on 2", 64'(active_ref), 64'd2);
    chk("R5 still closed", 64'(loop_closed), 64'd1);
    // R8 last loop word
    hist_valid = 0; fallback_single = 1; loop_ftw = 48'h0BAD_F00D_1234;
    ref_valid = 4'b0000;
    step("R8");
    loop_ftw = 48'h7777_0000_9999;
    #1; chk("R8 held loop word", 64'(ftw_out), 64'h0BAD_F00D_1234);
    step("R8");
    // R12 leave holdover on reference 3
    ref_valid = 4'b1000;
    step("R12"); step("R12"); step("R12");
    #1; chk("R12 tracking ref3", 64'(active_ref), 64'd3);
    chk("R12 closed", 64'(loop_closed), 64'd1);
    // R9 free-run word fallback
    fallback_single = 0; ref_valid = 4'b0000;
    step("R9");
    freerun_ftw = 48'h0F0F_0F0F_0F0F;
    #1; chk("R9 held freerun word", 64'(ftw_out), 64'h1111_2222_3333);
    step("R9");
    // R7 history first
    ref_valid = 4'b0001;
    step("R7"); step("R7"); step("R7");
    hist_valid = 1; fallback_single = 1; ref_valid = 4'b0000;
    step("R7");
    #1; chk("R7 held history", 64'(ftw_out), 64'h5555_6666_7777);
    hist_ftw = 48'h1234_5678_9ABC; loop_ftw = 48'h1;
    step("R10");
    #1; chk("R10 word unchanged", 64'(ftw_out), 64'h5555_6666_7777);
    // R6 switch on loss with another reference valid
    ref_valid = 4'b0011;
    step("R6"); step("R6"); step("R6");
    #1; chk("R6 tracking ref0", 64'(active_ref), 64'd0);
    ref_valid = 4'b0010;
    step("R6");
    #1; chk("R6 switched to ref1", 64'(active_ref), 64'd1);
    chk("R6 open in switch", 64'(loop_closed), 64'd0);
    step("R6"); step("R6");
    // R3 forced holdover
    force_hold = 1;
    step("R3");
    #1; chk("R3 open", 64'(loop_closed), 64'd0);
    chk("R3 history word", 64'(ftw_out), 64'h1234_5678_9ABC);
    // R2 free-run beats holdover
    force_freerun = 1;
    step("R2");
    #1; chk("R2 freerun word", 64'(ftw_out), 64'(freerun_ftw));
    chk("R2 open", 64'(loop_closed), 64'd0);
    force_freerun = 0; force_hold = 0;
    // R5 forced reference
    force_ref_en = 1; force_ref_idx = 2'd3; ref_valid = 4'b1010;
    step("R5"); step("R5"); step("R5");
    #1; chk("R5 forced ref3", 64'(active_ref), 64'd3);
    force_ref_idx = 2'd2;
    step("R5");
    #1; chk("R5 forced invalid holds", 64'(loop_closed), 64'd0);
    force_ref_en = 0;
    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 8 == 0) ref_valid[$urandom % NREF] ^= 1'b1;
      force_freerun = ($urandom % 48 == 0);
      force_hold    = ($urandom % 24 == 0);
      if ($urandom % 20 == 0) force_ref_en = ~force_ref_en;
      force_ref_idx = REF_W'($urandom);
      fallback_single = $urandom; hist_valid = ($urandom % 3 == 0);
      hist_ftw = {$urandom, $urandom}; loop_ftw = {$urandom, $urandom};
      if ($urandom % 4 == 0) freerun_ftw = {$urandom, $urandom};
      lock_in = NLOCK'($urandom);
      step("RND");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule